// File: doc/BRIEF.md
# Write Status Readback Generator

This block sits in the read path of a byte-wide nonvolatile memory model and decides what the data bus shows while an internal program or erase is running. When the busy flag from the external duration counter is low, the true array byte passes straight through. When it is high, the byte is replaced by two polling bits and zeros. The most significant bit reports completion: during a program it carries the inverted top bit of the byte being written, and during an erase it reads 0. The next bit down alternates on every read and starts at 1.

A host polls by reading repeatedly. It sees the toggling bit flip on each read and the top bit differ from its expected value until busy falls, and then it sees the array contents again. The read strobe is asynchronous to the block clock. It passes through a synchroniser, and only its falling edge (the end of a read) advances the toggle state. The driver enables for the data pads follow chip-enable and output-enable, both active low. The busy flag, the program/erase flag and the written byte are synchronous to the block clock and are driven by the command logic. That logic raises busy after the last write strobe of a command sequence: the fourth for program, the sixth for either erase.

Top module: `flash_poll_readback`

## Requirements
- R1: While busy_i=1 and erase_i=0, rd_data_o[7] equals the inverse of wr_byte_i[7].
- R2: While busy_i=1 and erase_i=1, rd_data_o[7] is 0.
- R3: While busy_i=1, each falling edge of rd_strobe_i inverts rd_data_o[6]. The new value is visible after the (SYNC_STAGES+1)th rising clock edge that follows the falling edge. rd_data_o[6] does not change at any other time during a busy period.
- R4: The first rd_data_o[6] value of every busy period is 1. Any clock edge sampled with busy_i=0 restores the toggle state to 1.
- R5: While busy_i=1, rd_data_o[5:0] are 0, and no bit of array_data_i reaches rd_data_o.
- R6: While busy_i=0, rd_data_o equals array_data_i in the same cycle, so the true data appears as soon as the operation completes.
- R7: dq_oe_o is all ones when ce_n_i=0 and oe_n_i=0, and all zeros in every other case.
- R8: While rst_n=0, the toggle state is 1 and the strobe synchroniser holds the idle (low) level.
- R9: Read strobes issued while busy_i=0 leave the toggle state unchanged, so the next busy period still starts with rd_data_o[6]=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Internal program or erase in progress |
| erase_i | input | 1 | 1 = erase operation, 0 = program operation |
| wr_byte_i | input | DATA_W | Byte being programmed |
| rd_strobe_i | input | 1 | Asynchronous read strobe, high during a read |
| array_data_i | input | DATA_W | True array data at the read address |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| rd_data_o | output | DATA_W | Byte presented on the data bus |
| dq_oe_o | output | DATA_W | Per-bit pad driver enables |

## Verification
The pass-through data, both polling bits in their current state, and the pad enables are combinational. The bench therefore sets these inputs on a falling clock edge and checks the outputs half a cycle later, with no clock edge in between. A read's effect on the toggling bit is due SYNC_STAGES+1 rising edges after the strobe falls. The bench checks that the bit has not changed after SYNC_STAGES edges and has flipped after one more edge. The busy-low restore to 1 takes one edge, so the bench lets exactly one edge pass between dropping and raising busy before it checks for the leading 1.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;

  // Completion bit shown while busy: inverted written MSB for program, 0 for erase
  function automatic logic poll_msb(input op_kind_e op, input logic wr_msb);
    return (op == OP_ERASE) ? 1'b0 : ~wr_msb;
  endfunction

  // Next toggle state given busy and a completed read
  function automatic logic next_toggle(input logic busy, input logic rd_done, input logic cur);
    if (!busy)   return 1'b1;
    if (rd_done) return ~cur;
    return cur;
  endfunction

endpackage

// File: rtl/flash_poll_strobe_sync.sv
module flash_poll_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic fall_o
);

  localparam int CHAIN_W = STAGES + 1;

  // chain_q[STAGES-1] is the synchronised strobe, chain_q[STAGES] its delayed copy
  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-2:0], strobe_i};
  end

  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/flash_poll_toggle.sv
module flash_poll_toggle
  import flash_poll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic rd_fall_i,
  output logic tgl_o
);

  logic tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b1;
    else        tgl_q <= next_toggle(busy_i, rd_fall_i, tgl_q);
  end

  assign tgl_o = tgl_q;

endmodule

// File: rtl/flash_poll_out_mux.sv
module flash_poll_out_mux
  import flash_poll_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              busy_i,
  input  op_kind_e          op_i,
  input  logic              wr_msb_i,
  input  logic              tgl_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] dq_oe_o
);

  localparam int POLL_BIT = DATA_W - 1;
  localparam int TGL_BIT  = DATA_W - 2;

  logic [DATA_W-1:0] status_w;
  logic              drive_w;

  for (genvar g = 0; g < DATA_W; g++) begin : g_status
    if (g == POLL_BIT) begin : g_poll
      assign status_w[g] = poll_msb(op_i, wr_msb_i);
    end else if (g == TGL_BIT) begin : g_tgl
      assign status_w[g] = tgl_i;
    end else begin : g_zero
      assign status_w[g] = 1'b0;
    end
  end

  assign drive_w   = ~ce_n_i & ~oe_n_i;
  assign rd_data_o = busy_i ? status_w : array_data_i;
  assign dq_oe_o   = {DATA_W{drive_w}};

endmodule

// File: rtl/flash_poll_readback.sv
module flash_poll_readback
  import flash_poll_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] wr_byte_i,
  input  logic              rd_strobe_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] dq_oe_o
);

  localparam int MSB = DATA_W - 1;

  // Named internal events for the checker
  logic     rd_fall_w;
  logic     tgl_q;
  op_kind_e op_w;
  logic     wr_low_unused;

  assign op_w          = erase_i ? OP_ERASE : OP_PROGRAM;
  assign wr_low_unused = ^wr_byte_i[MSB-1:0];

  flash_poll_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (rd_strobe_i),
    .fall_o   (rd_fall_w)
  );

  flash_poll_toggle u_toggle (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_i    (busy_i),
    .rd_fall_i (rd_fall_w),
    .tgl_o     (tgl_q)
  );

  flash_poll_out_mux #(.DATA_W(DATA_W)) u_mux (
    .busy_i       (busy_i),
    .op_i         (op_w),
    .wr_msb_i     (wr_byte_i[MSB]),
    .tgl_i        (tgl_q),
    .array_data_i (array_data_i),
    .ce_n_i       (ce_n_i),
    .oe_n_i       (oe_n_i),
    .rd_data_o    (rd_data_o),
    .dq_oe_o      (dq_oe_o)
  );

endmodule

// File: rtl/flash_poll_readback_chk.sv
module flash_poll_readback_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_i,
  input logic              erase_i,
  input logic              wr_msb_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic              ce_n_i,
  input logic              oe_n_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [DATA_W-1:0] dq_oe_o,
  input logic              rd_fall_w
);

  localparam int PB = DATA_W - 1;
  localparam int TB = DATA_W - 2;

  p_dq7_prog_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !erase_i) |-> (rd_data_o[PB] == !wr_msb_i));

  p_dq7_erase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && erase_i) |-> (rd_data_o[PB] == 1'b0));

  p_tgl_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && rd_fall_w) |=> (!busy_i || (rd_data_o[TB] != $past(rd_data_o[TB]))));

  p_tgl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !rd_fall_w) |=> (!busy_i || $stable(rd_data_o[TB])));

  p_first_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> rd_data_o[TB]);

  p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (rd_data_o[TB-1:0] == '0));

  p_idle_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (rd_data_o == array_data_i));

  p_oe_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_i && !oe_n_i) |-> (dq_oe_o == '1));

  p_oe_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n_i || oe_n_i) |-> (dq_oe_o == '0));

endmodule

bind flash_poll_readback flash_poll_readback_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_i       (busy_i),
  .erase_i      (erase_i),
  .wr_msb_i     (wr_byte_i[DATA_W-1]),
  .array_data_i (array_data_i),
  .ce_n_i       (ce_n_i),
  .oe_n_i       (oe_n_i),
  .rd_data_o    (rd_data_o),
  .dq_oe_o      (dq_oe_o),
  .rd_fall_w    (rd_fall_w)
);

// File: tb/test_flash_poll_readback.sv
module test_flash_poll_readback;
  localparam int DATA_W = 8;
  localparam int SYNC   = 2;
  localparam int NVEC   = 8;

  // {busy, erase, wr_byte, array, ce_n, oe_n, exp_data, exp_oe}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h3C, 8'hA5, 1'b0, 1'b0, 8'hA5, 8'hFF},  // R6 R7
    {1'b1, 1'b0, 8'h80, 8'hA5, 1'b0, 1'b0, 8'h40, 8'hFF},  // R1 R5
    {1'b1, 1'b0, 8'h12, 8'hFF, 1'b0, 1'b0, 8'hC0, 8'hFF},  // R1 R5
    {1'b1, 1'b1, 8'h12, 8'hFF, 1'b0, 1'b0, 8'h40, 8'hFF},  // R2
    {1'b1, 1'b1, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h40, 8'h00},  // R2 R7
    {1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b1, 8'hFF, 8'h00},  // R6 R7
    {1'b0, 1'b0, 8'h7E, 8'h7E, 1'b1, 1'b1, 8'h7E, 8'h00},  // R6 R7
    {1'b1, 1'b0, 8'h7F, 8'h5A, 1'b0, 1'b0, 8'hC0, 8'hFF}   // R1 R5
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              busy = 1'b1, erase = 1'b0, rd = 1'b0, ce_n = 1'b0, oe_n = 1'b0;
  logic [DATA_W-1:0] wr_byte = '0, array_data = 8'h33;
  logic [DATA_W-1:0] rd_data, dq_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  flash_poll_readback #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC)) i_flash_poll_readback (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .erase_i(erase), .wr_byte_i(wr_byte),
    .rd_strobe_i(rd), .array_data_i(array_data), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .rd_data_o(rd_data), .dq_oe_o(dq_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One read while busy: toggle bit must hold until SYNC+1 edges after the strobe falls
  task automatic busy_read(input logic before_v);
    @(negedge clk) rd = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 toggle held while strobe high", {7'd0, rd_data[6]}, {7'd0, before_v});
    rd = 1'b0;
    repeat (SYNC) @(negedge clk);
    chk("R3 toggle not yet advanced", {7'd0, rd_data[6]}, {7'd0, before_v});
    @(negedge clk);
    chk("R3 toggle advanced", {7'd0, rd_data[6]}, {7'd0, ~before_v});
  endtask

  task automatic idle_read();
    @(negedge clk) rd = 1'b1;
    repeat (4) @(negedge clk);
    rd = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
    chk("R9 idle read shows array", rd_data, array_data);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // Reset: toggle state 1, program of 8'h00 shows DQ7=1
    repeat (2) @(negedge clk);
    chk("R8 reset status byte", rd_data, 8'hC0);
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {busy, erase, wr_byte, array_data, ce_n, oe_n} = VEC[i][35:16];
      #1;
      chk($sformatf("R1/R2/R5/R6 vector %0d data", i), rd_data, VEC[i][15:8]);
      chk($sformatf("R7 vector %0d enables", i), dq_oe, VEC[i][7:0]);
    end

    // Program in progress: three reads
    @(negedge clk);
    busy = 1'b1; erase = 1'b0; wr_byte = 8'h00; array_data = 8'h77; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk("R4 first toggle value", rd_data, 8'hC0);
    busy_read(1'b1);
    busy_read(1'b0);
    busy_read(1'b1);
    chk("R5 array hidden while busy", rd_data, 8'h80);

    // Completion then new erase after exactly one idle edge
    @(negedge clk) busy = 1'b0;
    #1 chk("R6 true data on completion", rd_data, 8'h77);
    @(negedge clk);
    busy = 1'b1; erase = 1'b1;
    #1 chk("R4 toggle restored to 1", rd_data, 8'h40);
    busy_read(1'b1);
    chk("R2 erase status after one read", rd_data, 8'h00);
    @(negedge clk);
    busy = 1'b0; array_data = 8'hFF;
    #1 chk("R6 erased data after completion", rd_data, 8'hFF);

    // Reads while idle must not advance the toggle
    idle_read();
    idle_read();
    idle_read();
    @(negedge clk);
    busy = 1'b1; erase = 1'b0; wr_byte = 8'hFF;
    #1 chk("R9 toggle untouched by idle reads", rd_data, 8'h40);

    // Reset in the middle of a busy period with toggle at 0
    busy_read(1'b1);
    @(negedge clk) rst_n = 1'b0;
    #1 chk("R8 reset restores toggle", rd_data, 8'h40);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R8 toggle 1 after reset release", rd_data, 8'h40);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule